// File: doc/BRIEF.md
# GPIO expander register bank

This block is the register file and pin logic of a 16-pin general-purpose I/O expander. The pins form two 8-bit ports. A byte-wide access port (address, write data, write strobe, read strobe, read data) reaches one 8-bit register per port for each function: sampled pin level, output latch, read polarity, direction, interrupt mask and interrupt status. The serial bus slave that would drive this access port sits outside the block.

The block drives a level and an enable for each pin. It samples the pin levels through one register stage. It can invert each sampled bit on read. It pulls an active-low interrupt line while an unmasked input pin differs from the value software last read from that port. Reading a port's input register re-arms that port.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output latches read FFh, the polarity registers read 00h, the direction registers read FFh (all pins inputs), the mask registers read FFh (all masked), the status registers read 00h, `pin_oe` is 0 and `irq_n` is 1.
- R2: Reading address 00h (port 0, pins 7..0) or 01h (port 1, pins 15..8) returns the pin levels registered one clock earlier, XOR the matching polarity register. This holds whatever direction each pin is set to.
- R3: Writes to the input addresses 00h/01h and to the status addresses 4Ch/4Dh change nothing.
- R4: The output latches at 02h/03h read back the last value written to them, not the pin levels.
- R5: Direction registers sit at 06h/07h, with bit value 1 meaning input. `pin_oe[i]` is the inverse of the direction bit. `pin_out[i]` carries the latch bit when the pin is an output and 0 when it is an input.
- R6: Polarity registers at 04h/05h read back as written. A 1 inverts the matching bit of an input read.
- R7: A status bit (4Ch/4Dh) sets when its pin is an input, is unmasked (mask bit 0 at 4Ah/4Bh) and has a registered level that differs from the level captured at the last read of its port's input register. These levels are 0 after reset.
- R8: Reading 00h clears the port 0 status and captures port 0's current levels. Reading 01h does the same for port 1. Neither read disturbs the other port.
- R9: `irq_n` is 0 exactly while any status bit is set.
- R10: A masked pin or an output pin never sets its status bit.
- R11: Any address not listed above reads 00h and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, acts at the clock edge |
| rd_en | input | 1 | Read strobe, read side effects act at the clock edge |
| rdata | output | 8 | Read data, combinational from `addr` |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The pins are driven with mirrored byte patterns (5Ah/A5h). These show a port swap and a missing polarity XOR, and a read of a port set as output shows whether the read depends on direction. The interrupt path is tried in three ways: a masked port, an unmasked port whose pins are outputs, and an unmasked input port. Together they separate the mask gate, the direction gate and the compare against the last read. Alternating reads of the two ports show whether clearing one port leaks into the other. Stray writes to input, status and unused addresses, each followed by a read-back, show any decode that is too wide.

// File: rtl/gpio_regbank.sv
module gpio_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rdata,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe,
  output logic        irq_n
);
  localparam logic [7:0] A_IN0 = 8'h00, A_IN1 = 8'h01;
  localparam logic [7:0] A_OUT0 = 8'h02, A_OUT1 = 8'h03;
  localparam logic [7:0] A_POL0 = 8'h04, A_POL1 = 8'h05;
  localparam logic [7:0] A_DIR0 = 8'h06, A_DIR1 = 8'h07;
  localparam logic [7:0] A_MSK0 = 8'h4A, A_MSK1 = 8'h4B;
  localparam logic [7:0] A_STS0 = 8'h4C, A_STS1 = 8'h4D;

  logic [15:0] in_q, out_r, pol_r, dir_r, msk_r, sts_r, seen_r;
  logic [15:0] view, diff;
  logic [1:0]  rd_in;

  assign view    = in_q ^ pol_r;
  assign pin_oe  = ~dir_r;
  assign pin_out = out_r & ~dir_r;
  assign irq_n   = ~|sts_r;
  assign diff    = (in_q ^ seen_r) & dir_r & ~msk_r;
  assign rd_in   = {rd_en && addr == A_IN1, rd_en && addr == A_IN0};

  always_comb begin
    case (addr)
      A_IN0:   rdata = view[7:0];
      A_IN1:   rdata = view[15:8];
      A_OUT0:  rdata = out_r[7:0];
      A_OUT1:  rdata = out_r[15:8];
      A_POL0:  rdata = pol_r[7:0];
      A_POL1:  rdata = pol_r[15:8];
      A_DIR0:  rdata = dir_r[7:0];
      A_DIR1:  rdata = dir_r[15:8];
      A_MSK0:  rdata = msk_r[7:0];
      A_MSK1:  rdata = msk_r[15:8];
      A_STS0:  rdata = sts_r[7:0];
      A_STS1:  rdata = sts_r[15:8];
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_r <= 16'hFFFF;
      pol_r <= 16'h0000;
      dir_r <= 16'hFFFF;
      msk_r <= 16'hFFFF;
    end else if (wr_en) begin
      case (addr)
        A_OUT0: out_r[7:0]  <= wdata;
        A_OUT1: out_r[15:8] <= wdata;
        A_POL0: pol_r[7:0]  <= wdata;
        A_POL1: pol_r[15:8] <= wdata;
        A_DIR0: dir_r[7:0]  <= wdata;
        A_DIR1: dir_r[15:8] <= wdata;
        A_MSK0: msk_r[7:0]  <= wdata;
        A_MSK1: msk_r[15:8] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= '0;
      sts_r  <= '0;
      seen_r <= '0;
    end else begin
      in_q <= pin_in;
      for (int p = 0; p < 2; p++) begin
        if (rd_in[p]) begin
          sts_r[p*8 +: 8]  <= 8'h00;
          seen_r[p*8 +: 8] <= in_q[p*8 +: 8];
        end else begin
          sts_r[p*8 +: 8]  <= sts_r[p*8 +: 8] | diff[p*8 +: 8];
        end
      end
    end
  end

  p_masked_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sts_r & ~$past(sts_r) & $past(msk_r)) == 16'h0);
  p_output_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sts_r & ~$past(sts_r) & ~$past(dir_r)) == 16'h0);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_IN0) |=> sts_r[7:0] == 8'h00);
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_OUT0 || addr == A_OUT1)) |=> $stable(out_r));
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_DIR0 || addr == A_DIR1)) |=> $stable(pin_oe));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != 8'h00 && addr == A_STS0) |-> !irq_n);
endmodule

// File: tb/gpio_regbank_tb_top.sv
module gpio_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  logic        irq_n;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  gpio_regbank dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rd_en) begin
      if (sb_q.size() == 0) chk(32'd0, 32'd1, "scoreboard empty");
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk({24'd0, rdata}, {24'd0, it.exp}, it.tag);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #1;
    chk(pin_oe, 16'h0000, "R1 pin_oe");
    chk(pin_out, 16'h0000, "R1/R5 pin_out");
    chk(irq_n, 1, "R1 irq_n");
    rd(8'h02, 8'hFF, "R1 out0");
    rd(8'h03, 8'hFF, "R1 out1");
    rd(8'h04, 8'h00, "R1 pol0");
    rd(8'h07, 8'hFF, "R1 dir1");
    rd(8'h4A, 8'hFF, "R1 mask0");
    rd(8'h4D, 8'h00, "R1 status1");

    pin_in = 16'hA55A; idle(2);
    rd(8'h00, 8'h5A, "R2 in0");
    rd(8'h01, 8'hA5, "R2 in1");
    wr(8'h06, 8'h00);
    wr(8'h02, 8'h3C);
    idle(1); #1;
    chk(pin_oe, 16'h00FF, "R5 pin_oe");
    chk(pin_out, 16'h003C, "R5 pin_out");
    rd(8'h00, 8'h5A, "R2 in0 as output");
    rd(8'h02, 8'h3C, "R4 latch not pin");

    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h5A, "R3 write to input ignored");
    wr(8'h4C, 8'hFF);
    rd(8'h4C, 8'h00, "R3 write to status ignored");
    wr(8'h20, 8'h77);
    rd(8'h20, 8'h00, "R11 unused reads zero");
    rd(8'h02, 8'h3C, "R11 stray write left latch");

    wr(8'h05, 8'hF0);
    rd(8'h05, 8'hF0, "R6 pol readback");
    rd(8'h01, 8'h55, "R6 inverted read");

    pin_in = 16'h005A; idle(3); #1;
    chk(irq_n, 1, "R10 masked port quiet");
    wr(8'h4A, 8'h00);
    pin_in = 16'h005B; idle(3);
    rd(8'h4C, 8'h00, "R10 output pin quiet");

    wr(8'h4B, 8'h00);
    idle(3); #1;
    chk(irq_n, 0, "R9 irq asserted");
    rd(8'h4D, 8'hA5, "R7 status vs last read");
    rd(8'h01, 8'hF0, "R8 read input1");
    idle(1); #1;
    chk(irq_n, 1, "R9 irq released");
    rd(8'h4D, 8'h00, "R8 status1 cleared");

    pin_in = 16'h025B; idle(3);
    rd(8'h4D, 8'h02, "R7 single pin change");
    rd(8'h00, 8'h5B, "R2 in0 after change");
    rd(8'h4D, 8'h02, "R8 port0 read keeps port1");
    #1;
    chk(irq_n, 0, "R9 irq held");
    rd(8'h01, 8'hF2, "R8 read input1 again");
    rd(8'h4D, 8'h00, "R8 status1 cleared again");
    #1;
    chk(irq_n, 1, "R9 irq released again");
    chk(sb_q.size(), 0, "scoreboard drained");

    done = 1;
    finish_run();
  end
endmodule